// File: doc/BRIEF.md
# Stereo Channel Mixing Matrix

This block takes one stereo sample pair, a left and a right signed value, and builds the two output channels, A and B. A small mixing code picks the source of each output on its own. Each output can be silent, the left input, the right input, or the mean of the two inputs. The block sits between a serial audio receiver and the volume stage. Both outputs come from one register stage, so each accepted input pair produces exactly one output pair.

An input pair is taken only in a cycle where the input valid strobe is high. The mixing code is sampled in that same cycle. The result appears on the outputs one clock later, together with a one-cycle output valid strobe. Between accepted pairs the outputs keep their last value. The mean is rounded toward negative infinity and can never leave the signed sample range.

Top module: `stereo_mix_matrix`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_a and out_b are zero and out_valid is low.
- R2: mix_code[3:2] selects the source of out_a and mix_code[1:0] selects the source of out_b. The encoding for each field is 00 = zero (mute), 01 = right input, 10 = left input, 11 = mean of both inputs.
- R3: The mean is floor((left + right) / 2) over the full signed range. Examples: both inputs 0x7FFFFF gives 0x7FFFFF; both 0x800000 gives 0x800000; 0x800000 with 0x7FFFFF gives 0xFFFFFF (-1); -3 with 0 gives -2.
- R4: When mix_code[4] is 1, both outputs are zero, whatever mix_code[3:0] holds.
- R5: A pair accepted with in_valid high at a clock edge appears on out_a and out_b after that edge, with out_valid high for exactly that one cycle. Back-to-back valid cycles give back-to-back results.
- R6: In a cycle where in_valid is low, out_valid goes low at the next edge. out_a and out_b keep their values, whatever in_left, in_right and mix_code do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair and code are taken this cycle |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| mix_code | input | 5 | Mixing code: bit 4 forces mute, [3:2] source of A, [1:0] source of B |
| out_valid | output | 1 | One-cycle strobe, new output pair present |
| out_a | output | 24 | Channel A sample, two's complement |
| out_b | output | 24 | Channel B sample, two's complement |

## Verification
The assertions assume that in_valid, in_left, in_right and mix_code are stable and known at each rising edge once reset has been released. The bounds check on the mean also assumes that the samples are two's complement values. The bench drives all inputs only on falling edges and never leaves them undefined. It also raises in_valid only after reset has been released. Sample values go up to both extremes of the signed range, so the overflow bounds are exercised. None of them goes outside that range.

// File: rtl/mix_pkg.sv
package mix_pkg;

    // Per-output source field width inside the mixing code.
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_MUTE  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_MEAN  = 2'b11
    } src_sel_e;

    // Output channel indices
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/mix_code_decode.sv
module mix_code_decode
    import mix_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output src_sel_e          sel_a,
    output src_sel_e          sel_b
);

    localparam int B_LSB   = 0;
    localparam int A_LSB   = B_LSB + SEL_W;
    localparam int FIELD_W = A_LSB + SEL_W;

    logic force_mute;

    // Any code bit above the two source fields forces silence.
    generate
        if (CODE_W > FIELD_W) begin : g_resv
            assign force_mute = |code[CODE_W-1:FIELD_W];
        end else begin : g_no_resv
            assign force_mute = 1'b0;
        end
    endgenerate

    always_comb begin
        if (force_mute) begin
            sel_a = SRC_MUTE;
            sel_b = SRC_MUTE;
        end else begin
            sel_a = src_sel_e'(code[A_LSB +: SEL_W]);
            sel_b = src_sel_e'(code[B_LSB +: SEL_W]);
        end
    end

endmodule

// File: rtl/mix_pair_mean.sv
module mix_pair_mean #(
    parameter int SAMPLE_W = 24
) (
    input  logic signed [SAMPLE_W-1:0] left_s,
    input  logic signed [SAMPLE_W-1:0] right_s,
    output logic signed [SAMPLE_W-1:0] mean_s
);

    logic signed [SAMPLE_W-1:0] half_l;
    logic signed [SAMPLE_W-1:0] half_r;
    logic signed [SAMPLE_W-1:0] carry_s;

    // floor((l+r)/2) == floor(l/2) + floor(r/2) + (l0 & r0); no wider adder needed.
    always_comb begin
        half_l  = left_s >>> 1;
        half_r  = right_s >>> 1;
        carry_s = '0;
        carry_s[0] = left_s[0] & right_s[0];
        mean_s  = half_l + half_r + carry_s;
    end

endmodule

// File: rtl/mix_source_mux.sv
module mix_source_mux
    import mix_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  src_sel_e              sel,
    input  logic [SAMPLE_W-1:0]   left_s,
    input  logic [SAMPLE_W-1:0]   right_s,
    input  logic [SAMPLE_W-1:0]   mean_s,
    output logic [SAMPLE_W-1:0]   out_s
);

    always_comb begin
        unique case (sel)
            SRC_RIGHT: out_s = right_s;
            SRC_LEFT:  out_s = left_s;
            SRC_MEAN:  out_s = mean_s;
            default:   out_s = '0;
        endcase
    end

endmodule

// File: rtl/stereo_mix_matrix.sv
module stereo_mix_matrix
    import mix_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]   mix_code,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_a,
    output logic [SAMPLE_W-1:0] out_b
);

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] a;
        logic [SAMPLE_W-1:0] b;
    } out_state_t;

    out_state_t st_d, st_q;

    src_sel_e            sel_arr [N_CH];
    logic [SAMPLE_W-1:0] ch_out  [N_CH];
    logic signed [SAMPLE_W-1:0] mean_w;

    mix_code_decode #(.CODE_W(CODE_W)) u_decode (
        .code  (mix_code),
        .sel_a (sel_arr[CH_A]),
        .sel_b (sel_arr[CH_B])
    );

    mix_pair_mean #(.SAMPLE_W(SAMPLE_W)) u_mean (
        .left_s  ($signed(in_left)),
        .right_s ($signed(in_right)),
        .mean_s  (mean_w)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            mix_source_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
                .sel     (sel_arr[g]),
                .left_s  (in_left),
                .right_s (in_right),
                .mean_s  (mean_w),
                .out_s   (ch_out[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.a = ch_out[CH_A];
            st_d.b = ch_out[CH_B];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_a     = st_q.a;
    assign out_b     = st_q.b;

    // ---------------- assertions ----------------
    localparam int A_LSB = 2 * SEL_W - SEL_W;
    localparam int B_LSB = 0;
    localparam int FIELD_W = 2 * SEL_W;

    logic signed [SAMPLE_W-1:0] lo_s, hi_s;
    logic                       resv_set;
    assign lo_s = ($signed(in_left) < $signed(in_right)) ? $signed(in_left) : $signed(in_right);
    assign hi_s = ($signed(in_left) < $signed(in_right)) ? $signed(in_right) : $signed(in_left);
    assign resv_set = (CODE_W > FIELD_W) ? (mix_code >> FIELD_W) != '0 : 1'b0;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a) && $stable(out_b))); // R6
    AST_RESERVED_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && resv_set) |=> (out_a == '0 && out_b == '0)); // R4
    AST_MUTE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code[A_LSB +: SEL_W] == SRC_MUTE) |=> out_a == '0); // R2
    AST_MUTE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mix_code[B_LSB +: SEL_W] == SRC_MUTE) |=> out_b == '0); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !resv_set && mix_code[A_LSB +: SEL_W] == SRC_MEAN)
        |=> ($signed(out_a) >= $past(lo_s) && $signed(out_a) <= $past(hi_s))); // R3

endmodule

// File: tb/stereo_mix_matrix_tb.sv
module stereo_mix_matrix_tb_top;

    localparam int W  = 24;
    localparam int CW = 5;

    typedef struct packed {
        logic [1:0]    kind;   // 0: R2, 1: R3, 2: R4
        logic [CW-1:0] code;
        logic [W-1:0]  l;
        logic [W-1:0]  r;
        logic [W-1:0]  ea;
        logic [W-1:0]  eb;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'b00000, 24'h100000, 24'h000400, 24'h000000, 24'h000000},
        '{2'd0, 5'b00001, 24'h100000, 24'h000400, 24'h000000, 24'h000400},
        '{2'd0, 5'b00010, 24'h100000, 24'h000400, 24'h000000, 24'h100000},
        '{2'd0, 5'b00011, 24'h100000, 24'h000400, 24'h000000, 24'h080200},
        '{2'd0, 5'b00100, 24'h100000, 24'h000400, 24'h000400, 24'h000000},
        '{2'd0, 5'b00101, 24'h100000, 24'h000400, 24'h000400, 24'h000400},
        '{2'd0, 5'b01110, 24'h100000, 24'h000400, 24'h080200, 24'h100000},
        '{2'd0, 5'b01011, 24'h100000, 24'h000400, 24'h100000, 24'h080200},
        '{2'd0, 5'b01001, 24'h100000, 24'h000400, 24'h100000, 24'h000400},
        '{2'd2, 5'b10110, 24'h100000, 24'h000400, 24'h000000, 24'h000000},
        '{2'd2, 5'b11111, 24'h7FFFFF, 24'h7FFFFF, 24'h000000, 24'h000000},
        '{2'd1, 5'b01111, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF},
        '{2'd1, 5'b01111, 24'h800000, 24'h800000, 24'h800000, 24'h800000},
        '{2'd1, 5'b01111, 24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'hFFFFFF},
        '{2'd1, 5'b01111, 24'h000003, 24'h000000, 24'h000001, 24'h000001},
        '{2'd1, 5'b01111, 24'hFFFFFD, 24'h000000, 24'hFFFFFE, 24'hFFFFFE},
        '{2'd1, 5'b01111, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
        '{2'd1, 5'b00111, 24'h123456, 24'h654321, 24'h654321, 24'h3BBBBB}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_left = '0;
    logic [W-1:0]  in_right = '0;
    logic [CW-1:0] mix_code = '0;
    logic          out_valid;
    logic [W-1:0]  out_a, out_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stereo_mix_matrix #(.SAMPLE_W(W), .CODE_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .mix_code(mix_code),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic drive(input vec_t v, input logic vld);
        in_left  = v.l;
        in_right = v.r;
        mix_code = v.code;
        in_valid = vld;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep_a, keep_b;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", {23'd0, out_valid}, '0);
        chk("R1", "out_a in reset", out_a, '0);
        chk("R1", "out_b in reset", out_b, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", {23'd0, out_valid}, '0);
        chk("R1", "out_a after reset", out_a, '0);

        // Table walk: one valid pair, result one edge later
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R5", "out_valid after accept", {23'd0, out_valid}, 24'd1);
            chk(kind_tag(VECS[i].kind), $sformatf("vec %0d out_a", i), out_a, VECS[i].ea);
            chk(kind_tag(VECS[i].kind), $sformatf("vec %0d out_b", i), out_b, VECS[i].eb);
            @(negedge clk);
            chk("R5", "out_valid one cycle only", {23'd0, out_valid}, '0);
        end

        // R6: inputs change without in_valid, outputs hold
        drive(VECS[7], 1'b1);
        @(negedge clk);
        keep_a = out_a;
        keep_b = out_b;
        for (int j = 0; j < 4; j++) begin
            in_valid = 1'b0;
            in_left  = 24'hABCDE0 + 24'(j);
            in_right = 24'h13579B - 24'(j);
            mix_code = 5'(j * 7 + 1);
            @(negedge clk);
            chk("R6", "out_valid low w/o strobe", {23'd0, out_valid}, '0);
            chk("R6", "out_a held", out_a, keep_a);
            chk("R6", "out_b held", out_b, keep_b);
        end

        // R5: back-to-back accepted pairs
        drive(VECS[5], 1'b1);
        @(negedge clk);
        drive(VECS[16], 1'b1);
        chk("R5", "b2b first out_a", out_a, VECS[5].ea);
        chk("R5", "b2b first valid", {23'd0, out_valid}, 24'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5", "b2b second out_a", out_a, VECS[16].ea);
        chk("R5", "b2b second out_b", out_b, VECS[16].eb);
        chk("R5", "b2b second valid", {23'd0, out_valid}, 24'd1);
        @(negedge clk);

        // R1: reset in the middle of operation clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset out_a", out_a, '0);
        chk("R1", "mid reset out_b", out_b, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule